// File: doc/BRIEF.md
# Banked Register and Byte-Buffer SPI Slave

This block is an SPI slave that presents the control side of a network controller to a host. It holds four banks of thirty-two byte-wide registers, and a few top addresses are shared by every bank. It also holds a byte buffer that has separate auto-advancing read and write pointers. Every chip-select frame opens with a header byte. The top three bits of the header choose a command and the low five bits name a register. The commands are: read register, write register, set bits, clear bits, stream from the buffer, stream into the buffer, and soft reset. All SPI pins are brought into the system clock domain, so SCK must run several times slower than the system clock.

The active bank comes from the two low bits of the shared register at address 0x1F. Registers in the banks flagged as slow-class (banks 2 and 3 by default) answer a read with one padding byte of 0x00 before the value. A plain debug port can write and read any register directly, for preloading and inspection.

The SPI pins are a bit stream that the host paces with SCK, so the block applies no back-pressure and has no valid/ready handshake. A byte is consumed on its eighth rising SCK edge. The host has to keep each SCK half period at least six system clocks long.

Top module: `spi_regbuf_slave`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is sampled on rising SCK and MISO changes after falling SCK. Header bits 7:5 are the command (000 read reg, 001 buffer read, 010 write reg, 011 buffer write, 100 set bits, 101 clear bits, 111 soft reset) and bits 4:0 are the register address.
- R2: MISO carries 0x00 during the header byte. For a register outside the slow class, a read returns the value in the byte after the header.
- R3: A read of a slow-class register (banks 2 and 3, addresses 0x00–0x1A) returns 0x00 in the first byte after the header and the value in the second.
- R4: A write-register frame stores the byte after the header into the addressed register. Any later bytes in that frame have no effect.
- R5: The bank is bits 1:0 of register 0x1F. Addresses 0x1B–0x1F name one register each, whatever the bank.
- R6: A set-bits frame ORs its data byte into the register. A clear-bits frame ANDs in the complement. When the target is 0x1F, the bank changes.
- R7: A frame whose header is exactly 0x7A writes each following byte at the write pointer and then advances the pointer by one. The pointer wraps at the buffer depth (256).
- R8: A frame whose header is exactly 0x3A returns the byte at the read pointer in each following byte slot. The pointer advances once per byte consumed and wraps at the depth.
- R9: The soft-reset command clears bits 1:0 of register 0x1F and leaves its other bits unchanged.
- R10: A frame with opcode 110, or with opcode 001 or 011 but a header other than 0x3A or 0x7A, changes no register and no buffer state, and MISO stays 0x00.
- R11: MISO is 0 while chip select is high.
- R12: dbg_rdata shows the register at dbg_addr (bank in the top two bits, common addresses ignore the bank). dbg_we writes dbg_wdata there, and an SPI write in the same cycle takes priority.
- R13: Reset clears every register and both buffer pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Host-to-slave serial data |
| miso | output | 1 | Slave-to-host serial data |
| dbg_we | input | 1 | Debug register write strobe |
| dbg_addr | input | 7 | Debug register index {bank, address} |
| dbg_wdata | input | 8 | Debug write data |
| dbg_rdata | output | 8 | Register value at dbg_addr |

## Verification
The case that is hardest to reach is pointer wrap-around. Getting there takes a buffer-write frame of a full 256 bytes that starts at a non-zero pointer, followed by a full 256-byte read. The stimulus first streams three bytes, then writes a 256-byte pattern and reads it back in one frame, so any off-by-one in the pointer update or the prefetch shows up as a shifted pattern. Bank aliasing is reached by changing the bank through write, set-bits, clear-bits and soft reset, then reading the same address in each bank through the debug port.

// File: rtl/spirb_pkg.sv
package spirb_pkg;

  typedef enum logic [2:0] {
    OP_RDREG = 3'b000,
    OP_BUFRD = 3'b001,
    OP_WRREG = 3'b010,
    OP_BUFWR = 3'b011,
    OP_SETB  = 3'b100,
    OP_CLRB  = 3'b101,
    OP_SOFT  = 3'b111
  } op_e;

  typedef enum logic [3:0] {
    ST_HDR,
    ST_PAD,
    ST_WREG,
    ST_SETB,
    ST_CLRB,
    ST_BUFRD,
    ST_BUFWR,
    ST_IDLE,
    ST_DROP
  } frame_st_e;

  localparam logic [7:0] HDR_BUF_RD = 8'h3A;
  localparam logic [7:0] HDR_BUF_WR = 8'h7A;

endpackage

// File: rtl/spirb_sync.sv
module spirb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_start,
  output logic mosi_s
);
  // bit order {sck, cs_n, mosi}; chip select idles high
  localparam logic [2:0] IDLE = 3'b010;
  logic [2:0] s1, s2;
  logic sck_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= IDLE;
      s2    <= IDLE;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      s1    <= {sck, cs_n, mosi};
      s2    <= s1;
      sck_d <= s2[2];
      csn_d <= s2[1];
    end
  end

  assign sck_rise  = s2[2] & ~sck_d;
  assign sck_fall  = ~s2[2] & sck_d;
  assign cs_active = ~s2[1];
  assign cs_start  = ~s2[1] & csn_d;
  assign mosi_s    = s2[0];
endmodule

// File: rtl/spirb_regfile.sv
module spirb_regfile #(
  parameter int BANKS = 4,
  parameter int REGS = 32,
  parameter int COMMON_BASE = 27,
  parameter logic [BANKS-1:0] SLOW_BANKS = 4'b1100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(REGS)-1:0]       addr,
  output logic [7:0]                    rdata,
  output logic                          slow,
  input  logic                          we,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    ctrl,
  input  logic                          dbg_we,
  input  logic [$clog2(BANKS)+$clog2(REGS)-1:0] dbg_addr,
  input  logic [7:0]                    dbg_wdata,
  output logic [7:0]                    dbg_rdata
);
  localparam int BW = $clog2(BANKS);
  localparam int AW = $clog2(REGS);
  localparam int N  = BANKS * REGS;

  logic [7:0] mem [N];
  logic [BW-1:0] bank;

  function automatic logic [BW+AW-1:0] slot(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return (a >= AW'(COMMON_BASE)) ? {{BW{1'b0}}, a} : {b, a};
  endfunction

  assign ctrl      = mem[REGS-1];
  assign bank      = ctrl[BW-1:0];
  assign rdata     = mem[slot(bank, addr)];
  assign slow      = (addr < AW'(COMMON_BASE)) && SLOW_BANKS[bank];
  assign dbg_rdata = mem[slot(dbg_addr[BW+AW-1:AW], dbg_addr[AW-1:0])];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[slot(bank, addr)] <= wdata;
    end else if (dbg_we) begin
      mem[slot(dbg_addr[BW+AW-1:AW], dbg_addr[AW-1:0])] <= dbg_wdata;
    end
  end
endmodule

// File: rtl/spirb_buf.sv
module spirb_buf #(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_adv,
  output logic [7:0] rd_data,
  output logic [7:0] rd_next
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en)  wptr <= wptr + PW'(1);
      if (rd_adv) rptr <= rptr + PW'(1);
    end
  end

  assign rd_data = mem[rptr];
  assign rd_next = mem[rptr + PW'(1)];

  // R7
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr));
  // R8
  rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |=> rptr == PW'($past(rptr) + PW'(1)));
endmodule

// File: rtl/spi_regbuf_slave.sv
module spi_regbuf_slave
  import spirb_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int REGS = 32,
  parameter int BUF_DEPTH = 256,
  parameter int COMMON_BASE = 27,
  parameter logic [BANKS-1:0] SLOW_BANKS = 4'b1100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic       dbg_we,
  input  logic [6:0] dbg_addr,
  input  logic [7:0] dbg_wdata,
  output logic [7:0] dbg_rdata
);
  localparam int BW = $clog2(BANKS);
  localparam int AW = $clog2(REGS);
  localparam logic [7:0] BANK_MASK = 8'((1 << BW) - 1);

  logic sck_rise, sck_fall, cs_active, cs_start, mosi_s;
  logic [6:0] rx_sr;
  logic [2:0] bit_cnt;
  logic [7:0] rx_byte, tx_sr, tx_next;
  logic load_pend, byte_done;
  logic [AW-1:0] addr_q, rf_addr;
  logic [7:0] rf_rdata, rf_wdata, rf_ctrl, buf_rd, buf_rd_next;
  logic rf_slow, rf_we, buf_we, buf_adv;
  frame_st_e st;
  op_e op;

  spirb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
    .cs_start(cs_start), .mosi_s(mosi_s)
  );

  spirb_regfile #(
    .BANKS(BANKS), .REGS(REGS), .COMMON_BASE(COMMON_BASE), .SLOW_BANKS(SLOW_BANKS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(rf_addr), .rdata(rf_rdata), .slow(rf_slow),
    .we(rf_we), .wdata(rf_wdata), .ctrl(rf_ctrl), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr[BW+AW-1:0]), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  spirb_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_data(rx_byte),
    .rd_adv(buf_adv), .rd_data(buf_rd), .rd_next(buf_rd_next)
  );

  assign rx_byte   = {rx_sr, mosi_s};
  assign byte_done = cs_active && sck_rise && (bit_cnt == 3'd7);
  assign op        = op_e'(rx_byte[7:5]);
  assign miso      = cs_active ? tx_sr[7] : 1'b0;

  always_comb begin
    rf_addr  = (st == ST_HDR) ? rx_byte[AW-1:0] : addr_q;
    rf_we    = 1'b0;
    rf_wdata = rx_byte;
    buf_we   = 1'b0;
    buf_adv  = 1'b0;
    if (byte_done) begin
      case (st)
        ST_HDR: if (op == OP_SOFT) begin
          rf_addr  = '1;
          rf_we    = 1'b1;
          rf_wdata = rf_ctrl & ~BANK_MASK;
        end
        ST_WREG:  rf_we = 1'b1;
        ST_SETB:  begin rf_we = 1'b1; rf_wdata = rf_rdata | rx_byte;  end
        ST_CLRB:  begin rf_we = 1'b1; rf_wdata = rf_rdata & ~rx_byte; end
        ST_BUFWR: buf_we  = 1'b1;
        ST_BUFRD: buf_adv = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      rx_sr     <= '0;
      bit_cnt   <= '0;
      tx_sr     <= '0;
      tx_next   <= '0;
      load_pend <= 1'b0;
      addr_q    <= '0;
    end else if (!cs_active || cs_start) begin
      st        <= ST_HDR;
      bit_cnt   <= '0;
      tx_sr     <= '0;
      tx_next   <= '0;
      load_pend <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sr   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (sck_fall) begin
        if (load_pend) begin
          tx_sr     <= tx_next;
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
      if (byte_done) begin
        case (st)
          ST_HDR: begin
            addr_q <= rx_byte[AW-1:0];
            case (op)
              OP_RDREG: begin
                tx_next   <= rf_slow ? 8'h00 : rf_rdata;
                load_pend <= 1'b1;
                st        <= rf_slow ? ST_PAD : ST_IDLE;
              end
              OP_BUFRD: if (rx_byte == HDR_BUF_RD) begin
                tx_next   <= buf_rd;
                load_pend <= 1'b1;
                st        <= ST_BUFRD;
              end else st <= ST_DROP;
              OP_WRREG: st <= ST_WREG;
              OP_BUFWR: st <= (rx_byte == HDR_BUF_WR) ? ST_BUFWR : ST_DROP;
              OP_SETB:  st <= ST_SETB;
              OP_CLRB:  st <= ST_CLRB;
              OP_SOFT:  st <= ST_IDLE;
              default:  st <= ST_DROP;
            endcase
          end
          ST_PAD: begin
            tx_next   <= rf_rdata;
            load_pend <= 1'b1;
            st        <= ST_IDLE;
          end
          ST_WREG, ST_SETB, ST_CLRB: st <= ST_IDLE;
          ST_BUFRD: begin
            tx_next   <= buf_rd_next;
            load_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> (tx_sr == 8'h00));
  // R9
  soft_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_HDR && rx_byte[7:5] == 3'b111) |=> ((rf_ctrl & BANK_MASK) == 8'h00));
  // R10
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP) |-> (!rf_we && !buf_we && !buf_adv && !miso));
  // R11
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !miso);
endmodule

// File: tb/spi_regbuf_slave_bench.sv
module spi_regbuf_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic dbg_we = 1'b0;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_wdata = '0;
  logic [7:0] dbg_rdata;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  localparam time HALF = 200ns;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string tag_q[$];

  always #10ns clk = ~clk;

  spi_regbuf_slave u_spi_regbuf_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 1);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: compares captured MISO bytes against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic frame_open();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic frame_close();
    #(HALF);
    cs_n = 1'b1;
    #(HALF * 2);
  endtask

  // driver: shifts one byte, pushes the expected MISO byte when care is set
  task automatic xfer(input logic [7:0] b, input logic [7:0] e, input bit care, input string tag);
    logic [7:0] r;
    if (care) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      #(HALF);
      r[i] = miso;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    if (care) got_q.push_back(r);
  endtask

  task automatic two(input logic [7:0] h, input logic [7:0] d);
    frame_open();
    xfer(h, 8'h00, 1'b0, "");
    xfer(d, 8'h00, 1'b0, "");
    frame_close();
  endtask

  task automatic dbg_chk(input logic [1:0] bank, input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    dbg_addr = {bank, a};
    #5ns;
    check(tag, dbg_rdata, exp);
  endtask

  initial begin
    #(4ms);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100ns;
    rst_n = 1'b1;
    #100ns;
    // R13 reset state, R11 idle MISO
    dbg_chk(2'd0, 5'h00, 8'h00, "R13 reg after reset");
    dbg_chk(2'd0, 5'h1F, 8'h00, "R13 bank reg after reset");
    checks++;
    if (miso !== 1'b0) begin errors++; $display("FAIL R11 actual=%b expected=0", miso); end

    // R4 write, R1 framing, R2 read
    frame_open();
    xfer(8'h45, 8'h00, 1'b0, "");
    xfer(8'hA5, 8'h00, 1'b0, "");
    xfer(8'hFF, 8'h00, 1'b0, "");
    frame_close();
    dbg_chk(2'd0, 5'h05, 8'hA5, "R4 write reg");
    dbg_chk(2'd0, 5'h06, 8'h00, "R4 extra byte ignored");
    frame_open();
    xfer(8'h05, 8'h00, 1'b1, "R2 header quiet");
    xfer(8'h00, 8'hA5, 1'b1, "R1 R2 read value");
    frame_close();

    // R5 bank select and slow-class padding (R3)
    two(8'h5F, 8'h02);
    two(8'h45, 8'h3C);
    dbg_chk(2'd2, 5'h05, 8'h3C, "R5 bank2 write");
    dbg_chk(2'd0, 5'h05, 8'hA5, "R5 bank0 untouched");
    frame_open();
    xfer(8'h05, 8'h00, 1'b1, "R3 header");
    xfer(8'h00, 8'h00, 1'b1, "R3 pad byte");
    xfer(8'h00, 8'h3C, 1'b1, "R3 value after pad");
    frame_close();
    two(8'h5B, 8'h77);
    dbg_chk(2'd0, 5'h1B, 8'h77, "R5 common addr");
    dbg_chk(2'd3, 5'h1B, 8'h77, "R5 common via dbg bank");

    // R6 set/clear bits
    two(8'hBF, 8'h02);
    dbg_chk(2'd0, 5'h1F, 8'h00, "R6 clear bank bit");
    two(8'h85, 8'h0A);
    dbg_chk(2'd0, 5'h05, 8'hAF, "R6 set bits");
    two(8'hA5, 8'h21);
    dbg_chk(2'd0, 5'h05, 8'h8E, "R6 clear bits");
    two(8'h9F, 8'h01);
    two(8'h50, 8'h11);
    dbg_chk(2'd1, 5'h10, 8'h11, "R6 set bank bit selects bank1");

    // R9 soft reset
    two(8'h5F, 8'hC3);
    frame_open();
    xfer(8'hFF, 8'h00, 1'b0, "");
    frame_close();
    dbg_chk(2'd0, 5'h1F, 8'hC0, "R9 soft reset clears bank bits");

    // R7 R8 buffer streams with wrap
    frame_open();
    xfer(8'h7A, 8'h00, 1'b0, "");
    xfer(8'h11, 8'h00, 1'b0, "");
    xfer(8'h22, 8'h00, 1'b0, "");
    xfer(8'h33, 8'h00, 1'b0, "");
    frame_close();
    frame_open();
    xfer(8'h3A, 8'h00, 1'b1, "R8 header quiet");
    xfer(8'h00, 8'h11, 1'b1, "R7 R8 byte0");
    xfer(8'h00, 8'h22, 1'b1, "R7 R8 byte1");
    xfer(8'h00, 8'h33, 1'b1, "R7 R8 byte2");
    frame_close();
    frame_open();
    xfer(8'h7A, 8'h00, 1'b0, "");
    for (int i = 0; i < 256; i++) xfer(pat(i), 8'h00, 1'b0, "");
    frame_close();
    frame_open();
    xfer(8'h3A, 8'h00, 1'b0, "");
    for (int i = 0; i < 256; i++) xfer(8'h00, pat(i), 1'b1, "R7 R8 wrap pattern");
    frame_close();

    // R10 ignored frames
    frame_open();
    xfer(8'h3B, 8'h00, 1'b1, "R10 bad read hdr");
    xfer(8'h00, 8'h00, 1'b1, "R10 bad read data quiet");
    frame_close();
    two(8'h7B, 8'h55);
    two(8'hC5, 8'h44);
    dbg_chk(2'd0, 5'h05, 8'h8E, "R10 unknown opcode no write");
    frame_open();
    xfer(8'h3A, 8'h00, 1'b0, "");
    xfer(8'h00, pat(0), 1'b1, "R10 bad write hdr no buffer write");
    frame_close();

    // R12 debug preload visible over SPI
    @(negedge clk);
    dbg_addr = {2'd0, 5'h06};
    dbg_wdata = 8'h5A;
    dbg_we = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0;
    frame_open();
    xfer(8'h06, 8'h00, 1'b0, "");
    xfer(8'h00, 8'h5A, 1'b1, "R12 debug write read over SPI");
    frame_close();
    checks++;
    if (miso !== 1'b0) begin errors++; $display("FAIL R11 actual=%b expected=0", miso); end

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule